// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block is a clocked controller that runs an external asynchronous static RAM of 32K bytes. It has a 15-bit address, an 8-bit data bus split into output, output-enable and input lanes for the pad ring, and three active-low strobes: chip select, write strobe and read (output) enable. On the host side it takes one single-word read or write at a time through a valid/ready handshake. It returns read data with a one-cycle valid pulse and reports the end of each write with a one-cycle done pulse.

Every interval on the memory side is a whole number of clock cycles. Each one is computed when the block is built, from the selected speed grade (35, 55 or 70 ns) and the clock period, by rounding the nanosecond limit up. A build option chooses how writes treat the read enable. In the default mode the read enable stays high for the whole write. In the other mode it stays low, and the write strobe is then lengthened so that the memory's output turn-off time and the data setup time both fit inside it. The controller's own bus drivers stay off for the turn-off part of the pulse.

The address changes only while chip select and write strobe are both high. After every read, the controller waits out the memory's output turn-off time before it accepts another request.

Top module: `sram_ctrl`

## Requirements
- R1: While rst_ni is low, all three strobes are high, the data drivers are off and no response pulse is given; after release, req_ready_o is high.
- R2: Strobe encodings: idle means all strobes high; a read holds chip select and read enable low with the write strobe high; a write holds chip select and write strobe low; with OE_LOW_WR=0 the read enable stays high for every cycle of a write.
- R3: mem_addr_o changes only in a cycle where chip select and write strobe are high and were also high in the cycle before.
- R4: A read keeps chip select and read enable low for exactly RD = ceil(access time / clock period) cycles and samples mem_dq_i at the last clock edge of that window; rsp_valid_o rises RD+1 cycles after the accepting edge and carries the sampled byte.
- R5: After a read, the strobes stay high for REC = ceil(output turn-off time / clock period) cycles before req_ready_o returns, and the data drivers are never on while the memory may still be driving.
- R6: The write strobe is low for WP cycles, the largest of ceil(pulse width), ceil(address/select to end of write), ceil(write cycle) minus 2, and the cycles needed under R7 and R8; wr_done_o rises WP+2 cycles after the accepting edge.
- R7: During a write the data drivers carry a stable byte for the final WP-TURN cycles of the strobe, which is at least ceil(data setup / clock period). They stay on in the cycle after the strobe rises and are off in the cycle after that.
- R8: With OE_LOW_WR=1, the read enable is low for every cycle of the write strobe, the drivers stay off for the first TURN = ceil(turn-off time / clock period) cycles of the strobe, and WP >= TURN + ceil(data setup / clock period). Chip select and write strobe always fall in the same cycle.
- R9: A request is taken only while req_ready_o is high. req_ready_o is low from the cycle after acceptance until the operation ends. rsp_valid_o and wr_done_o are each high for exactly one cycle.
- R10: A byte written to an address is returned by every later read of that address until the address is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_we_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | One-cycle read data strobe |
| rsp_rdata_o | output | DW | Read data |
| wr_done_o | output | 1 | One-cycle write completion strobe |
| mem_addr_o | output | AW | Memory address bus |
| mem_ce_no | output | 1 | Memory chip select, active low |
| mem_we_no | output | 1 | Memory write strobe, active low |
| mem_oe_no | output | 1 | Memory read enable, active low |
| mem_dq_o | output | DW | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Enable for the data drivers |
| mem_dq_i | input | DW | Data received from the memory |

## Verification
Two instances, one in each write mode, run side by side against a behavioural memory. That memory returns garbage until the access window has elapsed and keeps driving for the turn-off time after a read, so a read window that is too short shows up as bad data and an early drive shows up as bus contention. First, every address of a reduced 8-bit address space is written with an odd-multiplier pattern and then read back in descending order. This finds address aliasing and tells the two write modes apart by their strobe length, driver turnaround and read-enable level. A sparse overwrite pass then runs each write right after another transaction and reads it back at once. It exercises back-to-back write-then-read and read-then-write turnarounds, which a linear sweep alone would not separate.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RD,
    ST_RD_REC,
    ST_WR,
    ST_WR_END
  } seq_st_e;

  typedef enum int unsigned {
    TP_ACC,   // address/select access, read and write cycle
    TP_WIN,   // address valid / select low to end of write
    TP_WP,    // write strobe width
    TP_DSU,   // data setup to end of write
    TP_HZ     // output turn-off after select/enable/strobe
  } tparam_e;

  function automatic int unsigned grade_ns(int unsigned grade, tparam_e p);
    int unsigned g;
    g = (grade > 2) ? 2 : grade;
    case (p)
      TP_ACC:  return (g == 0) ? 35 : (g == 1) ? 55 : 70;
      TP_WIN:  return (g == 0) ? 30 : (g == 1) ? 50 : 60;
      TP_WP:   return (g == 0) ? 25 : (g == 1) ? 45 : 55;
      TP_DSU:  return (g == 0) ? 20 : (g == 1) ? 25 : 30;
      default: return (g == 0) ? 15 : (g == 1) ? 20 : 25;
    endcase
  endfunction

  function automatic int unsigned ceil_div(int unsigned a, int unsigned b);
    return (a + b - 1) / b;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned sat_sub(int unsigned a, int unsigned b);
    return (a > b) ? a - b : 0;
  endfunction

endpackage

// File: rtl/sram_cycle_cnt.sv
`timescale 1ns/1ps
module sram_cycle_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (load_i)     cnt_q <= load_val_i;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq import sram_ctrl_pkg::*; #(
  parameter int unsigned RD_CYC    = 4,
  parameter int unsigned REC_CYC   = 2,
  parameter int unsigned WP_CYC    = 3,
  parameter int unsigned TURN_CYC  = 0,
  parameter bit          OE_LOW_WR = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_we_i,
  output logic ready_o,
  output logic latch_o,
  output logic capture_o,
  output logic done_o,
  output logic ce_no,
  output logic we_no,
  output logic oe_no,
  output logic drive_o
);
  localparam int unsigned MAXC = max2(max2(RD_CYC, REC_CYC), WP_CYC);
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RD_LD   = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] REC_LD  = CW'(REC_CYC - 1);
  localparam logic [CW-1:0] WP_LD   = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] DRV_LIM = CW'(WP_CYC - TURN_CYC);

  seq_st_e       state_q, state_d;
  logic          is_wr_q;
  logic          load;
  logic [CW-1:0] load_val;
  logic [CW-1:0] cnt;
  logic          cnt_zero;
  logic          ce_q, we_q, oe_q, done_q;

  sram_cycle_cnt #(.W(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .cnt_o      (cnt),
    .zero_o     (cnt_zero)
  );

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    load_val  = '0;
    latch_o   = 1'b0;
    capture_o = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid_i) begin
        state_d = ST_SETUP;
        latch_o = 1'b1;
      end
      ST_SETUP: begin
        load = 1'b1;
        if (is_wr_q) begin
          state_d  = ST_WR;
          load_val = WP_LD;
        end else begin
          state_d  = ST_RD;
          load_val = RD_LD;
        end
      end
      ST_RD: if (cnt_zero) begin
        state_d   = ST_RD_REC;
        load      = 1'b1;
        load_val  = REC_LD;
        capture_o = 1'b1;
      end
      ST_RD_REC: if (cnt_zero) state_d = ST_IDLE;
      ST_WR:     if (cnt_zero) state_d = ST_WR_END;
      ST_WR_END: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
      ce_q    <= 1'b1;
      we_q    <= 1'b1;
      oe_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (latch_o) is_wr_q <= req_we_i;
      // strobes registered from next state: glitch-free pins
      ce_q   <= !(state_d == ST_RD || state_d == ST_WR);
      we_q   <= !(state_d == ST_WR);
      oe_q   <= !(state_d == ST_RD || (OE_LOW_WR && state_d == ST_WR));
      done_q <= (state_q == ST_WR_END);
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign done_o  = done_q;
  assign ce_no   = ce_q;
  assign we_no   = we_q;
  assign oe_no   = oe_q;
  // drivers on for the tail of the strobe, held one cycle past its rise
  assign drive_o = ((state_q == ST_WR) && (cnt < DRV_LIM)) || (state_q == ST_WR_END);

  AST_WE_WITH_CE: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(we_no) |-> $fell(ce_no)) else $error("write strobe fell without select"); // R8
  AST_OE_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni) !we_no |-> (oe_no == !OE_LOW_WR)) else $error("read enable wrong during write"); // R2
  AST_NO_CONTEND: assert property (@(posedge clk_i) disable iff (!rst_ni) (!ce_no && !oe_no && we_no) |-> !drive_o) else $error("drive during read"); // R5
  AST_DRV_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni) (drive_o && we_no) |=> !drive_o) else $error("drivers held too long"); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o) else $error("done wider than one cycle"); // R9
endmodule

// File: rtl/sram_dq_path.sv
`timescale 1ns/1ps
module sram_dq_path #(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          latch_i,
  input  logic          capture_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          rsp_valid_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      if (latch_i) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (capture_i) rdata_q <= mem_dq_i;
      rsp_q <= capture_i;
    end
  end

  assign addr_o      = addr_q;
  assign wdata_o     = wdata_q;
  assign rdata_o     = rdata_q;
  assign rsp_valid_o = rsp_q;
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl import sram_ctrl_pkg::*; #(
  parameter int unsigned AW        = 15,
  parameter int unsigned DW        = 8,
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned GRADE     = 0,    // 0:35ns 1:55ns 2:70ns
  parameter bit          OE_LOW_WR = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          wr_done_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_no,
  output logic          mem_we_no,
  output logic          mem_oe_no,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int unsigned ACC_C  = ceil_div(grade_ns(GRADE, TP_ACC), CLK_NS);
  localparam int unsigned WIN_C  = ceil_div(grade_ns(GRADE, TP_WIN), CLK_NS);
  localparam int unsigned WPM_C  = ceil_div(grade_ns(GRADE, TP_WP),  CLK_NS);
  localparam int unsigned DSU_C  = ceil_div(grade_ns(GRADE, TP_DSU), CLK_NS);
  localparam int unsigned HZ_C   = ceil_div(grade_ns(GRADE, TP_HZ),  CLK_NS);
  localparam int unsigned TURN_C = OE_LOW_WR ? HZ_C : 0;
  // setup and end cycles add 2 to the strobe for the write cycle time
  localparam int unsigned WP_C   = max2(max2(WPM_C, WIN_C),
                                        max2(sat_sub(ACC_C, 2), TURN_C + DSU_C));

  logic latch, capture;

  sram_seq #(
    .RD_CYC    (ACC_C),
    .REC_CYC   (HZ_C),
    .WP_CYC    (WP_C),
    .TURN_CYC  (TURN_C),
    .OE_LOW_WR (OE_LOW_WR)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .ready_o     (req_ready_o),
    .latch_o     (latch),
    .capture_o   (capture),
    .done_o      (wr_done_o),
    .ce_no       (mem_ce_no),
    .we_no       (mem_we_no),
    .oe_no       (mem_oe_no),
    .drive_o     (mem_dq_oe_o)
  );

  sram_dq_path #(.AW(AW), .DW(DW)) u_dq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .latch_i     (latch),
    .capture_i   (capture),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .mem_dq_i    (mem_dq_i),
    .addr_o      (mem_addr_o),
    .wdata_o     (mem_dq_o),
    .rdata_o     (rsp_rdata_o),
    .rsp_valid_o (rsp_valid_o)
  );

  AST_ADDR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) !$stable(mem_addr_o) |-> (mem_ce_no && mem_we_no && $past(mem_ce_no) && $past(mem_we_no))) else $error("address moved under strobe"); // R3
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) rsp_valid_o |=> !rsp_valid_o) else $error("read valid wider than one cycle"); // R9
  AST_RSP_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni) rsp_valid_o |-> (mem_ce_no && mem_oe_no && $past(!mem_ce_no) && $past(!mem_oe_no))) else $error("read data outside window"); // R4
endmodule

// File: tb/sram_ctrl_test.sv
`timescale 1ns/1ps
module sram_model #(
  parameter int AW  = 8,
  parameter int ACC = 4,
  parameter int HZ  = 2
) (
  input  logic          clk,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic          dq_oe,
  output logic [7:0]    dout,
  output int            last_rd,
  output int            last_wp,
  output int            last_drv,
  output int            last_turn,
  output int            last_oe,
  output int            last_hold,
  output int            n_addr,
  output int            n_bus
);
  logic [7:0] mem [0:(1<<AW)-1];
  logic [AW-1:0] addr_p = '0;
  logic ce_p = 1'b1, we_p = 1'b1, wr_p = 1'b0;
  logic [7:0] wdat = 8'h00;
  int rd_cnt = 0, hz = 0, wp_cnt = 0, drv_cnt = 0, turn_cnt = 0, oe_cnt = 0;
  int l_rd = 0, l_wp = 0, l_drv = 0, l_turn = 0, l_oe = 0, l_hold = 0, c_addr = 0, c_bus = 0;
  wire rd_on = !ce_n && !oe_n && we_n;
  wire wr_on = !ce_n && !we_n;

  assign dout = (rd_on && rd_cnt + 1 >= ACC) ? mem[addr] : 8'hEE;
  assign last_rd = l_rd;   assign last_wp = l_wp;     assign last_drv = l_drv;
  assign last_turn = l_turn; assign last_oe = l_oe;   assign last_hold = l_hold;
  assign n_addr = c_addr;  assign n_bus = c_bus;

  always @(posedge clk) begin
    addr_p <= addr; ce_p <= ce_n; we_p <= we_n; wr_p <= wr_on;
    if (addr != addr_p && !(ce_n && we_n && ce_p && we_p)) c_addr <= c_addr + 1;
    if (rd_on) begin rd_cnt <= rd_cnt + 1; l_rd <= rd_cnt + 1; hz <= HZ; end
    else begin rd_cnt <= 0; if (hz > 0) hz <= hz - 1; end
    if (dq_oe && (rd_on || hz > 0)) c_bus <= c_bus + 1;
    if (wr_on) begin
      wp_cnt <= wp_cnt + 1;
      if (!oe_n) oe_cnt <= oe_cnt + 1;
      if (dq_oe) begin
        if (drv_cnt == 0) turn_cnt <= wp_cnt;
        drv_cnt <= (drv_cnt > 0 && din != wdat) ? 1 : drv_cnt + 1;
        wdat <= din;
      end
    end else if (wr_p) begin
      mem[addr] <= wdat;
      l_wp <= wp_cnt; l_drv <= drv_cnt; l_turn <= turn_cnt; l_oe <= oe_cnt;
      l_hold <= dq_oe ? 1 : 0;
      wp_cnt <= 0; drv_cnt <= 0; turn_cnt <= 0; oe_cnt <= 0;
    end
  end
endmodule

module sram_ctrl_test;
  localparam int CLK_PERIOD = 10;
  // expected cycle counts at 35 ns grade, 10 ns clock
  localparam int EXP_RD   = (35 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int EXP_HZ   = (15 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int EXP_DSU  = (20 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int EXP_WP_A = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int EXP_WP_B = EXP_HZ + EXP_DSU;

  logic clk = 1'b0, rst_ni = 1'b1;
  logic valid_a = 1'b0, valid_b = 1'b0, req_we = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic ready_a, rvalid_a, wdone_a, ce_a, we_a, oe_a, oe_en_a;
  logic ready_b, rvalid_b, wdone_b, ce_b, we_b, oe_b, oe_en_b;
  logic [7:0] rdata_a, rdata_b, maddr_a, maddr_b, dqo_a, dqo_b, dqi_a, dqi_b;
  int rd_a, wp_a, drv_a, turn_a, oec_a, hold_a, nad_a, nbus_a;
  int rd_b, wp_b, drv_b, turn_b, oec_b, hold_b, nad_b, nbus_b;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl #(.AW(8), .DW(8), .CLK_NS(CLK_PERIOD), .GRADE(0), .OE_LOW_WR(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(valid_a), .req_ready_o(ready_a),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rvalid_a), .rsp_rdata_o(rdata_a), .wr_done_o(wdone_a),
    .mem_addr_o(maddr_a), .mem_ce_no(ce_a), .mem_we_no(we_a), .mem_oe_no(oe_a),
    .mem_dq_o(dqo_a), .mem_dq_oe_o(oe_en_a), .mem_dq_i(dqi_a));

  sram_ctrl #(.AW(8), .DW(8), .CLK_NS(CLK_PERIOD), .GRADE(0), .OE_LOW_WR(1'b1)) uut_b (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(valid_b), .req_ready_o(ready_b),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rvalid_b), .rsp_rdata_o(rdata_b), .wr_done_o(wdone_b),
    .mem_addr_o(maddr_b), .mem_ce_no(ce_b), .mem_we_no(we_b), .mem_oe_no(oe_b),
    .mem_dq_o(dqo_b), .mem_dq_oe_o(oe_en_b), .mem_dq_i(dqi_b));

  sram_model #(.AW(8), .ACC(EXP_RD), .HZ(EXP_HZ)) mem_a (
    .clk(clk), .ce_n(ce_a), .we_n(we_a), .oe_n(oe_a), .addr(maddr_a), .din(dqo_a),
    .dq_oe(oe_en_a), .dout(dqi_a), .last_rd(rd_a), .last_wp(wp_a), .last_drv(drv_a),
    .last_turn(turn_a), .last_oe(oec_a), .last_hold(hold_a), .n_addr(nad_a), .n_bus(nbus_a));

  sram_model #(.AW(8), .ACC(EXP_RD), .HZ(EXP_HZ)) mem_b (
    .clk(clk), .ce_n(ce_b), .we_n(we_b), .oe_n(oe_b), .addr(maddr_b), .din(dqo_b),
    .dq_oe(oe_en_b), .dout(dqi_b), .last_rd(rd_b), .last_wp(wp_b), .last_drv(drv_b),
    .last_turn(turn_b), .last_oe(oec_b), .last_hold(hold_b), .n_addr(nad_b), .n_bus(nbus_b));

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle_check();
    int n;
    n = 0;
    while (!(ready_a && ready_b) && n < 20) begin @(negedge clk); n++; end
    chk_eq("R2", "idle strobes a", int'({ce_a, we_a, oe_a, oe_en_a}), 4'b1110);
    chk_eq("R2", "idle strobes b", int'({ce_b, we_b, oe_b, oe_en_b}), 4'b1110);
  endtask

  task automatic do_op(input bit we, input logic [7:0] a, input logic [7:0] d,
                       output int ra, output int rb, output int la, output int lb);
    int cyc, acc_a, acc_b, fin_a, fin_b;
    cyc = 0; acc_a = -1; acc_b = -1; fin_a = -1; fin_b = -1;
    ra = 0; rb = 0; la = -1; lb = -1;
    req_we = we; req_addr = a; req_wdata = d; valid_a = 1'b1; valid_b = 1'b1;
    while (cyc < 40 && !(fin_a >= 0 && fin_b >= 0 && cyc >= fin_a + 2 && cyc >= fin_b + 2)) begin
      if (valid_a && ready_a) acc_a = cyc + 1;
      if (valid_b && ready_b) acc_b = cyc + 1;
      @(posedge clk); cyc++;
      @(negedge clk);
      if (cyc == acc_a) begin valid_a = 1'b0; chk_eq("R9", "busy ready a", int'(ready_a), 0); end
      if (cyc == acc_b) begin valid_b = 1'b0; chk_eq("R9", "busy ready b", int'(ready_b), 0); end
      if (fin_a < 0 && acc_a >= 0 && (we ? wdone_a : rvalid_a)) begin
        fin_a = cyc; la = cyc - acc_a; ra = int'(rdata_a);
        if (we) chk_eq("R9", "ready with done a", int'(ready_a), 1);
      end else if (fin_a >= 0 && cyc == fin_a + 1) begin
        chk_eq("R9", "pulse width a", int'(we ? wdone_a : rvalid_a), 0);
        if (!we) chk_eq("R5", "recovery busy a", int'(ready_a), 0);
      end else if (fin_a >= 0 && cyc == fin_a + 2 && !we)
        chk_eq("R5", "ready after recovery a", int'(ready_a), 1);
      if (fin_b < 0 && acc_b >= 0 && (we ? wdone_b : rvalid_b)) begin
        fin_b = cyc; lb = cyc - acc_b; rb = int'(rdata_b);
        if (we) chk_eq("R9", "ready with done b", int'(ready_b), 1);
      end else if (fin_b >= 0 && cyc == fin_b + 1) begin
        chk_eq("R9", "pulse width b", int'(we ? wdone_b : rvalid_b), 0);
        if (!we) chk_eq("R5", "recovery busy b", int'(ready_b), 0);
      end else if (fin_b >= 0 && cyc == fin_b + 2 && !we)
        chk_eq("R5", "ready after recovery b", int'(ready_b), 1);
    end
    valid_a = 1'b0; valid_b = 1'b0;
  endtask

  task automatic write_op(input logic [7:0] a, input logic [7:0] d);
    int ra, rb, la, lb;
    do_op(1'b1, a, d, ra, rb, la, lb);
    chk_eq("R6", "write latency a", la, EXP_WP_A + 2);
    chk_eq("R8", "write latency b", lb, EXP_WP_B + 2);
    chk_eq("R6", "strobe width a", wp_a, EXP_WP_A);
    chk_eq("R8", "strobe width b", wp_b, EXP_WP_B);
    chk_eq("R7", "stable drive a", drv_a, EXP_WP_A);
    chk_eq("R7", "stable drive b", drv_b, EXP_WP_B - EXP_HZ);
    chk_eq("R8", "turnaround a", turn_a, 0);
    chk_eq("R8", "turnaround b", turn_b, EXP_HZ);
    chk_eq("R2", "oe low in write a", oec_a, 0);
    chk_eq("R8", "oe low in write b", oec_b, EXP_WP_B);
    chk_eq("R7", "hold after end a", hold_a, 1);
    chk_eq("R7", "hold after end b", hold_b, 1);
    idle_check();
  endtask

  task automatic read_op(input logic [7:0] a, input logic [7:0] exp);
    int ra, rb, la, lb;
    do_op(1'b0, a, 8'h00, ra, rb, la, lb);
    chk_eq("R10", "read data a", ra, int'(exp));
    chk_eq("R10", "read data b", rb, int'(exp));
    chk_eq("R4", "read latency a", la, EXP_RD + 1);
    chk_eq("R4", "read latency b", lb, EXP_RD + 1);
    chk_eq("R4", "read window a", rd_a, EXP_RD);
    chk_eq("R4", "read window b", rd_b, EXP_RD);
    idle_check();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R1", "reset pins a", int'({ce_a, we_a, oe_a, oe_en_a, rvalid_a, wdone_a}), 6'b111000);
    chk_eq("R1", "reset pins b", int'({ce_b, we_b, oe_b, oe_en_b, rvalid_b, wdone_b}), 6'b111000);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_eq("R1", "ready after reset a", int'(ready_a), 1);
    chk_eq("R1", "ready after reset b", int'(ready_b), 1);

    for (int a = 0; a < 256; a++) write_op(8'(a), 8'(a * 37 + 11));
    for (int a = 255; a >= 0; a--) read_op(8'(a), 8'(a * 37 + 11));
    for (int a = 0; a < 256; a += 17) begin
      write_op(8'(a), ~8'(a * 37 + 11));
      read_op(8'(a), ~8'(a * 37 + 11));
      read_op(8'(a ^ 1), 8'((a ^ 1) * 37 + 11));
    end

    chk_eq("R3", "address moves under strobe a", nad_a, 0);
    chk_eq("R3", "address moves under strobe b", nad_b, 0);
    chk_eq("R5", "bus contention a", nbus_a, 0);
    chk_eq("R5", "bus contention b", nbus_b, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule